// File: doc/BRIEF.md
# Legacy I/O Port Decoder and Register Bank

This block is a Wishbone slave that sits behind a bridge turning low-pin-count host cycles into bus cycles. It gives the classic PC I/O map on a 32-bit bus whose accesses are always single bytes on the lowest data lane. The 16-bit I/O address is decoded into chip selects for four serial-port windows of eight bytes each and for a two-address keyboard/mouse controller window. The external peripheral cores behind those windows answer the cycle themselves: their read byte and acknowledge pass straight through to the bus.

Two addresses are held locally as power-on self-test code latches. Each of them drives its own output byte and reads back what was last written. A block of eight board registers is also held locally. A write sets an output byte that leaves the chip. A read of the same address returns a separate input byte from the board, not the written value. Any strobe that matches none of these ranges ends with an error and changes nothing.

Top module: `legacy_io_decoder`

## Requirements
- R1: Serial windows are selected by the address ranges 0x3F8–0x3FF (`com_sel_o[0]`), 0x2F8–0x2FF (`com_sel_o[1]`), 0x3E8–0x3EF (`com_sel_o[2]`) and 0x2E8–0x2EF (`com_sel_o[3]`). A select is high only while a strobe is active, and at most one window select is high at a time. `win_ofs_o` carries address bits 2:0.
- R2: Only addresses 0x60 and 0x64 raise `kbd_sel_o`. `kbd_cmd_o` is address bit 2, so 0x60 is data and 0x64 is command/status. Neighbours such as 0x61 are unmapped.
- R3: While a window is selected, `wb_ack_o` equals that window's ack input and `wb_dat_o[7:0]` equals its read byte. `win_we_o` and `win_wdata_o` carry the bus write enable and data bits 7:0.
- R4: A write to 0x80 sets `post_lo_o` and a write to 0x81 sets `post_hi_o`. A read of either address returns the byte last written there.
- R5: A write to 0x200+n (n = 0..7) sets `brd_out_o[8n+7:8n]`. A read of 0x200+n returns `brd_in_i[8n+7:8n]`.
- R6: For a local address (post-code or board), `wb_ack_o` rises one cycle after the strobe and stays high for exactly one cycle. A strobe performs exactly one write. `wb_dat_o[31:8]` is always zero.
- R7: A strobe to an unmapped address raises `wb_err_o` for exactly one cycle and never `wb_ack_o`. It raises no window select and changes no post-code or board output.
- R8: Synchronous active-low reset clears both post-code outputs and all eight board output bytes to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wb_cyc_i | input | 1 | Bus cycle |
| wb_stb_i | input | 1 | Bus strobe |
| wb_we_i | input | 1 | Write enable |
| wb_adr_i | input | 16 | I/O address |
| wb_dat_i | input | 32 | Write data, bits 7:0 used |
| wb_dat_o | output | 32 | Read data, bits 31:8 zero |
| wb_ack_o | output | 1 | Cycle acknowledge |
| wb_err_o | output | 1 | Unmapped-address error |
| com_sel_o | output | 4 | Serial window selects |
| win_ofs_o | output | 3 | Register offset inside a window |
| win_we_o | output | 1 | Window write enable |
| win_wdata_o | output | 8 | Window write byte |
| com_rdata_i | input | 32 | Serial window read bytes, byte n for window n |
| com_ack_i | input | 4 | Serial window acks |
| kbd_sel_o | output | 1 | Keyboard window select |
| kbd_cmd_o | output | 1 | 1 = command/status port, 0 = data port |
| kbd_rdata_i | input | 8 | Keyboard window read byte |
| kbd_ack_i | input | 1 | Keyboard window ack |
| post_lo_o | output | 8 | Post-code byte at 0x80 |
| post_hi_o | output | 8 | Post-code byte at 0x81 |
| brd_out_o | output | 64 | Board register output bytes |
| brd_in_i | input | 64 | Board register input bytes |

## Verification
Two functions share a cycle in a board-register write. At one clock edge the output byte is updated and the local acknowledge is raised, while the read path still points at the input byte. The bench writes one value and drives a different input byte. It then checks, one cycle after the strobe, that the ack is present and that the output holds the new value. It checks the same for a read of that address, which must show the input byte. A strobe held across that edge must not write twice or acknowledge twice. This is judged by the ack dropping on the next cycle.

// File: rtl/legacy_io_pkg.sv
// Package: shared constants for the legacy I/O decoder.
// Assumes 16-bit I/O addresses and byte-wide registers.
package legacy_io_pkg;
    localparam int ADDR_W  = 16;
    localparam int DATA_W  = 32;
    localparam int BYTE_W  = 8;
    localparam int NUM_COM = 4;
    localparam int NUM_BRD = 8;
    localparam int NUM_PST = 2;
    localparam int WIN_AW  = 3;                    // offset bits in a serial window
    localparam int BRD_AW  = $clog2(NUM_BRD);
    // index order is the select order on com_sel_o
    localparam logic [ADDR_W-1:0] COM_BASE [NUM_COM] =
        '{16'h03F8, 16'h02F8, 16'h03E8, 16'h02E8};
    localparam logic [ADDR_W-1:0] KBD_DATA = 16'h0060;
    localparam logic [ADDR_W-1:0] KBD_CMD  = 16'h0064;
    localparam logic [ADDR_W-1:0] PST_BASE = 16'h0080;
    localparam logic [ADDR_W-1:0] BRD_BASE = 16'h0200;
endpackage

// File: rtl/io_addr_decode.sv
// Module: io_addr_decode
// Purely combinational map of an I/O address onto the window and local
// register classes. Assumes base addresses aligned to their range size.
module io_addr_decode
    import legacy_io_pkg::*;
(
    input  logic [ADDR_W-1:0]  adr,
    output logic [NUM_COM-1:0] com_hit,
    output logic               kbd_hit,
    output logic               pst_hit,
    output logic               brd_hit,
    output logic               miss
);
    localparam int PST_AW = $clog2(NUM_PST);

    // one comparator per serial window on the upper address bits
    for (genvar i = 0; i < NUM_COM; i++) begin : g_com
        assign com_hit[i] = (adr[ADDR_W-1:WIN_AW] == COM_BASE[i][ADDR_W-1:WIN_AW]);
    end

    // keyboard, post-code and board ranges, then the miss flag
    always_comb begin
        kbd_hit = (adr == KBD_DATA) || (adr == KBD_CMD);
        pst_hit = (adr[ADDR_W-1:PST_AW] == PST_BASE[ADDR_W-1:PST_AW]);
        brd_hit = (adr[ADDR_W-1:BRD_AW] == BRD_BASE[ADDR_W-1:BRD_AW]);
        miss    = ~(|com_hit | kbd_hit | pst_hit | brd_hit);
    end
endmodule

// File: rtl/io_local_regs.sv
// Module: io_local_regs
// Holds the post-code latches and the board output registers, and builds
// the local read byte. Assumes wr_en is a single-cycle pulse per strobe.
module io_local_regs
    import legacy_io_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic                      pst_hit,
    input  logic                      brd_hit,
    input  logic [BRD_AW-1:0]         ofs,
    input  logic [BYTE_W-1:0]         wdata,
    input  logic [NUM_BRD*BYTE_W-1:0] brd_in,
    output logic [NUM_PST*BYTE_W-1:0] pst_out,
    output logic [NUM_BRD*BYTE_W-1:0] brd_out,
    output logic [BYTE_W-1:0]         rdata
);
    localparam int PST_AW = $clog2(NUM_PST);

    // post-code latches, one per address
    for (genvar p = 0; p < NUM_PST; p++) begin : g_pst
        always_ff @(posedge clk) begin
            if (!rst_n)
                pst_out[p*BYTE_W +: BYTE_W] <= '0;
            else if (wr_en && pst_hit && ofs[PST_AW-1:0] == PST_AW'(p))
                pst_out[p*BYTE_W +: BYTE_W] <= wdata;
        end
    end

    // board output registers, one per address
    for (genvar b = 0; b < NUM_BRD; b++) begin : g_brd
        always_ff @(posedge clk) begin
            if (!rst_n)
                brd_out[b*BYTE_W +: BYTE_W] <= '0;
            else if (wr_en && brd_hit && ofs == BRD_AW'(b))
                brd_out[b*BYTE_W +: BYTE_W] <= wdata;
        end
    end

    // read byte: post-code reads back itself, board reads its input byte
    always_comb begin
        if (pst_hit)
            rdata = pst_out[ofs[PST_AW-1:0]*BYTE_W +: BYTE_W];
        else if (brd_hit)
            rdata = brd_in[ofs*BYTE_W +: BYTE_W];
        else
            rdata = '0;
    end

    // registers only move on a write that hits them
    assert_post_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && pst_hit) |=> $stable(pst_out));
    assert_board_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && brd_hit) |=> $stable(brd_out));
    assert_post_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (pst_out == '0));
    assert_board_clear_R8: assert property (@(posedge clk)
        !rst_n |=> (brd_out == '0));
endmodule

// File: rtl/io_bus_resp.sv
// Module: io_bus_resp
// Generates ack/err and the read data. Local hits get a registered
// one-cycle ack; window hits forward the peripheral's ack and byte.
module io_bus_resp
    import legacy_io_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              local_hit,
    input  logic              win_hit,
    input  logic              miss,
    input  logic              win_ack,
    input  logic [BYTE_W-1:0] win_rdata,
    input  logic [BYTE_W-1:0] local_rdata,
    output logic              local_go,
    output logic              ack,
    output logic [DATA_W-1:0] dat,
    output logic              err
);
    logic ack_q;
    logic err_q;

    assign local_go = req && local_hit && !ack_q;

    // one-cycle ack for local hits, one-cycle err for misses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            ack_q <= local_go;
            err_q <= req && miss && !err_q;
        end
    end

    // response mux: window pass-through or local
    always_comb begin
        ack = (req && win_hit) ? win_ack : ack_q;
        err = err_q;
        dat = '0;
        dat[BYTE_W-1:0] = win_hit ? win_rdata : local_rdata;
    end

    assert_single_ack_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack_q |=> !ack_q);
    assert_single_err_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> !err_q);
    assert_err_no_ack_R7: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> !ack);
endmodule

// File: rtl/legacy_io_decoder.sv
// Module: legacy_io_decoder (top)
// Wishbone slave that maps the PC legacy I/O space onto serial and keyboard
// window selects, post-code latches and board registers. Assumes byte-wide
// cycles on data bits 7:0 and a master that holds the strobe until ack/err.
module legacy_io_decoder
    import legacy_io_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wb_cyc_i,
    input  logic                      wb_stb_i,
    input  logic                      wb_we_i,
    input  logic [ADDR_W-1:0]         wb_adr_i,
    input  logic [DATA_W-1:0]         wb_dat_i,
    output logic [DATA_W-1:0]         wb_dat_o,
    output logic                      wb_ack_o,
    output logic                      wb_err_o,
    output logic [NUM_COM-1:0]        com_sel_o,
    output logic [WIN_AW-1:0]         win_ofs_o,
    output logic                      win_we_o,
    output logic [BYTE_W-1:0]         win_wdata_o,
    input  logic [NUM_COM*BYTE_W-1:0] com_rdata_i,
    input  logic [NUM_COM-1:0]        com_ack_i,
    output logic                      kbd_sel_o,
    output logic                      kbd_cmd_o,
    input  logic [BYTE_W-1:0]         kbd_rdata_i,
    input  logic                      kbd_ack_i,
    output logic [BYTE_W-1:0]         post_lo_o,
    output logic [BYTE_W-1:0]         post_hi_o,
    output logic [NUM_BRD*BYTE_W-1:0] brd_out_o,
    input  logic [NUM_BRD*BYTE_W-1:0] brd_in_i
);
    logic [NUM_COM-1:0]        com_hit;
    logic                      kbd_hit, pst_hit, brd_hit, miss;
    logic                      req, win_hit, win_ack, local_go;
    logic [BYTE_W-1:0]         win_rdata, local_rdata;
    logic [NUM_PST*BYTE_W-1:0] pst_out;
    logic                      unused_hi;

    assign req       = wb_cyc_i && wb_stb_i;
    assign unused_hi = ^wb_dat_i[DATA_W-1:BYTE_W];

    io_addr_decode u_dec (
        .adr(wb_adr_i), .com_hit(com_hit), .kbd_hit(kbd_hit),
        .pst_hit(pst_hit), .brd_hit(brd_hit), .miss(miss)
    );

    // window selects, shared offset/data and the forwarded response
    always_comb begin
        com_sel_o   = com_hit & {NUM_COM{req}};
        kbd_sel_o   = kbd_hit && req;
        kbd_cmd_o   = wb_adr_i[2];
        win_ofs_o   = wb_adr_i[WIN_AW-1:0];
        win_we_o    = wb_we_i;
        win_wdata_o = wb_dat_i[BYTE_W-1:0];
        win_hit     = |com_hit || kbd_hit;
        win_ack     = |(com_ack_i & com_hit) || (kbd_ack_i && kbd_hit);
        win_rdata   = kbd_hit ? kbd_rdata_i : '0;
        for (int i = 0; i < NUM_COM; i++)
            if (com_hit[i]) win_rdata = com_rdata_i[i*BYTE_W +: BYTE_W];
    end

    io_local_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(local_go && wb_we_i),
        .pst_hit(pst_hit), .brd_hit(brd_hit), .ofs(wb_adr_i[BRD_AW-1:0]),
        .wdata(wb_dat_i[BYTE_W-1:0]), .brd_in(brd_in_i),
        .pst_out(pst_out), .brd_out(brd_out_o), .rdata(local_rdata)
    );

    assign post_lo_o = pst_out[0 +: BYTE_W];
    assign post_hi_o = pst_out[BYTE_W +: BYTE_W];

    io_bus_resp u_resp (
        .clk(clk), .rst_n(rst_n), .req(req),
        .local_hit(pst_hit || brd_hit), .win_hit(win_hit), .miss(miss),
        .win_ack(win_ack), .win_rdata(win_rdata), .local_rdata(local_rdata),
        .local_go(local_go), .ack(wb_ack_o), .dat(wb_dat_o), .err(wb_err_o)
    );

    assert_one_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({com_sel_o, kbd_sel_o}));
    assert_err_no_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wb_err_o |-> (com_sel_o == '0 && !kbd_sel_o));
endmodule

// File: tb/tb_legacy_io_decoder.sv
module tb_legacy_io_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
    logic [15:0] adr = '0;
    logic [31:0] wdat = '0;
    logic [31:0] rdat;
    logic        ack, err;
    logic [3:0]  com_sel;
    logic [2:0]  ofs;
    logic        wwe;
    logic [7:0]  wwd;
    logic        kbd_sel, kbd_cmd;
    logic [7:0]  post_lo, post_hi;
    logic [63:0] brd_out;
    logic [63:0] brd_in = 64'hB7B6B5B4B3B2B1B0;
    logic [31:0] com_rdata = 32'h44332211;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    legacy_io_decoder dut (
        .clk(clk), .rst_n(rst_n), .wb_cyc_i(cyc), .wb_stb_i(stb), .wb_we_i(we),
        .wb_adr_i(adr), .wb_dat_i(wdat), .wb_dat_o(rdat), .wb_ack_o(ack),
        .wb_err_o(err), .com_sel_o(com_sel), .win_ofs_o(ofs), .win_we_o(wwe),
        .win_wdata_o(wwd), .com_rdata_i(com_rdata), .com_ack_i(com_sel),
        .kbd_sel_o(kbd_sel), .kbd_cmd_o(kbd_cmd), .kbd_rdata_i(8'h5A),
        .kbd_ack_i(kbd_sel), .post_lo_o(post_lo), .post_hi_o(post_hi),
        .brd_out_o(brd_out), .brd_in_i(brd_in)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // vector: adr[35:20] we[19] wdata[18:11] kind[10:8] exp[7:0]
    // kind 0 local, 1 serial (exp = window index), 2 keyboard (exp = cmd bit), 3 unmapped
    localparam int NV = 19;
    localparam logic [35:0] VEC [NV] = '{
        {16'h0080, 1'b1, 8'h12, 3'd0, 8'h00},  // R4
        {16'h0081, 1'b1, 8'h34, 3'd0, 8'h00},  // R4
        {16'h0080, 1'b0, 8'h00, 3'd0, 8'h12},  // R4 readback
        {16'h0081, 1'b0, 8'h00, 3'd0, 8'h34},  // R4 readback
        {16'h0200, 1'b1, 8'hA5, 3'd0, 8'h00},  // R5
        {16'h0207, 1'b1, 8'h5A, 3'd0, 8'h00},  // R5
        {16'h0200, 1'b0, 8'h00, 3'd0, 8'hB0},  // R5 input byte
        {16'h0207, 1'b0, 8'h00, 3'd0, 8'hB7},  // R5 input byte
        {16'h03F8, 1'b0, 8'h00, 3'd1, 8'h00},  // R1
        {16'h02FF, 1'b0, 8'h00, 3'd1, 8'h01},  // R1
        {16'h03EB, 1'b1, 8'h77, 3'd1, 8'h02},  // R1 R3
        {16'h02EC, 1'b0, 8'h00, 3'd1, 8'h03},  // R1
        {16'h0060, 1'b0, 8'h00, 3'd2, 8'h00},  // R2
        {16'h0064, 1'b1, 8'h99, 3'd2, 8'h01},  // R2
        {16'h0061, 1'b0, 8'h00, 3'd3, 8'h00},  // R2 R7
        {16'h0208, 1'b1, 8'hFF, 3'd3, 8'h00},  // R7
        {16'h0082, 1'b1, 8'hFF, 3'd3, 8'h00},  // R7
        {16'h03F0, 1'b0, 8'h00, 3'd3, 8'h00},  // R7
        {16'h03F7, 1'b1, 8'h11, 3'd3, 8'h00}   // R7
    };

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R8 reset post", {48'h0, post_hi, post_lo}, 64'h0);
        check("R8 reset board", brd_out, 64'h0);
        check("R6 idle ack", {63'h0, ack}, 64'h0);

        for (int v = 0; v < NV; v++) begin
            logic [15:0] a; logic w; logic [7:0] d; logic [2:0] k; logic [7:0] e;
            {a, w, d, k, e} = VEC[v];
            @(negedge clk);
            cyc = 1'b1; stb = 1'b1; we = w; adr = a; wdat = {24'hFFFFFF, d};
            @(posedge clk); #1;
            case (k)
                3'd0: begin
                    check("R6 local ack", {62'h0, ack, err}, 64'h2);
                    check("R6 upper zero", {40'h0, rdat[31:8]}, 64'h0);
                    if (!w) check("R4/R5 read", {56'h0, rdat[7:0]}, {56'h0, e});
                    if (w && a == 16'h0200) check("R5 out byte0", {56'h0, brd_out[7:0]}, {56'h0, d});
                    if (w && a == 16'h0081) check("R4 post hi", {56'h0, post_hi}, {56'h0, d});
                end
                3'd1: begin
                    check("R1 select", {60'h0, com_sel}, 64'h1 << e);
                    check("R1 offset", {61'h0, ofs}, {61'h0, a[2:0]});
                    check("R3 ack/data", {55'h0, ack, rdat[7:0]},
                          {55'h0, 1'b1, 8'h11 * (e + 8'd1)});
                    if (w) check("R3 write path", {55'h0, wwe, wwd}, {55'h0, 1'b1, d});
                end
                3'd2: begin
                    check("R2 kbd select", {61'h0, kbd_sel, kbd_cmd, |com_sel}, {61'h0, 1'b1, e[0], 1'b0});
                    check("R3 kbd ack/data", {55'h0, ack, rdat[7:0]}, {55'h0, 1'b1, 8'h5A});
                end
                default: begin
                    check("R7 err", {62'h0, ack, err}, 64'h1);
                    check("R7 no select", {59'h0, kbd_sel, com_sel}, 64'h0);
                end
            endcase
            @(negedge clk); cyc = 1'b0; stb = 1'b0; we = 1'b0;
            @(posedge clk); #1;
            check("R6/R7 one-cycle response", {62'h0, ack, err}, 64'h0);
        end

        // held strobe on a local write: ack exactly one cycle, value written once
        @(negedge clk); cyc = 1'b1; stb = 1'b1; we = 1'b1; adr = 16'h0203; wdat = 32'h0000003C;
        @(posedge clk); #1;
        check("R6 held strobe ack", {63'h0, ack}, 64'h1);
        check("R5 byte3 written", {56'h0, brd_out[31:24]}, 64'h3C);
        @(posedge clk); #1;
        check("R6 held strobe no second ack", {63'h0, ack}, 64'h0);
        @(negedge clk); cyc = 1'b0; stb = 1'b0; we = 1'b0;

        // unmapped writes left everything else as written
        @(negedge clk);
        check("R7 board untouched", brd_out, 64'h5A0000003C0000A5);
        check("R7 post untouched", {48'h0, post_hi, post_lo}, 64'h3412);

        // reset clears all local outputs
        rst_n = 1'b0;
        @(posedge clk); #1;
        check("R8 board cleared", brd_out, 64'h0);
        check("R8 post cleared", {48'h0, post_hi, post_lo}, 64'h0);
        @(negedge clk); rst_n = 1'b1;

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule